// File: doc/BRIEF.md
# Sideband Doorbell Mailbox Bridge

This block gives a host a small register window through which it can issue one non-posted, single-dword transaction at a time onto an internal sideband message fabric. The host loads a target address and a data word, then writes a command word to a doorbell register. That write launches the request and sets a busy bit, which the host polls. Busy clears by itself when the target answers. After a read, the data register holds the returned word.

The command word carries device/function, opcode, destination port, byte enables and a BAR selector. The bridge uses the port field to route a one-hot request valid to one of `NUM_PORTS` endpoints. It then waits for that endpoint's ready, and after that for a response on a shared return channel. Opcodes 0x00 and 0x06 are reads. Every other opcode is carried as a write. A programmable cycle limit bounds the wait. When the limit runs out, the bridge gives up, completes a read with all ones, and records a sticky timeout flag. A doorbell write that arrives while busy is dropped and records a sticky overrun flag.

Top module: `sb_mailbox_bridge`

## Requirements
- R1: After reset, the address, data and doorbell registers read 0 with busy (doorbell bit 0) clear, the control register reads the `DEFAULT_TMO` limit with both flags clear, and no request valid is asserted.
- R2: Register select 0 is address, 1 is data, 2 is doorbell and 3 is control. A doorbell write while idle stores the command word and sets busy from the next cycle on. The doorbell reads back the stored word with bit 0 replaced by busy.
- R3: While a request is outstanding, exactly the valid line whose index equals the port field (bits 15:8) is high. It stays high, with stable fields, until the edge where ready is sampled. A port value of `NUM_PORTS` or more raises no line.
- R4: The request carries device/function from bits 31:24, opcode from bits 23:16, byte enables from bits 7:4 and BAR from bits 3:1. The address and data come from their registers.
- R5: The read flag is high exactly for opcodes 0x00 and 0x06.
- R6: For a read, the edge that samples the response valid clears busy and loads the response word into the data register.
- R7: For a write, the response clears busy and leaves the data register unchanged.
- R8: A doorbell write while busy is ignored, and it sets the sticky overrun flag (control bit 17).
- R9: Address and data register writes while busy are ignored.
- R10: If no response has arrived by the edge that follows the limit-th edge after launch, the bridge clears busy, withdraws any pending valid and sets the sticky timeout flag (control bit 16). A read then leaves 0xFFFFFFFF in the data register, and a write leaves the data register unchanged.
- R11: A control write loads the limit from its low `TMO_W` bits. Writing 1 to bit 16 or bit 17 clears the matching flag, and writing 0 leaves it unchanged.
- R12: A response valid that arrives while the bridge is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostSel | input | 2 | Register select: 0 address, 1 data, 2 doorbell, 3 control |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Contents of the selected register (combinational) |
| fabReqValid | output | NUM_PORTS | One-hot request valid, one line per destination port |
| fabReqReady | input | 1 | Selected endpoint accepts the request |
| fabDevFn | output | 8 | Device/function field of the request |
| fabOpcode | output | 8 | Opcode field of the request |
| fabByteEn | output | 4 | Byte enables of the request |
| fabBar | output | 3 | BAR selector of the request |
| fabIsRead | output | 1 | Request is a read |
| fabAddr | output | 32 | Request address |
| fabWdata | output | 32 | Request write data |
| fabRspValid | input | 1 | Response strobe from the endpoint |
| fabRspData | input | 32 | Response read data |

## Verification
The bench builds the bridge with `NUM_PORTS`=4, `TMO_W`=8 and `DEFAULT_TMO`=12. With four routes, every valid line can be driven, and port values 4 and 7 land out of range, which exercises the no-route case. The short default limit, later rewritten to 5, makes the exact timeout edge reachable within a few cycles. The bench can therefore check busy one edge before expiry and one edge after it, both for a request that is never accepted and for one that is accepted but never answered.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  // host register selects
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_BELL = 2'd2;
  localparam logic [1:0] SEL_CTL  = 2'd3;

  // command word layout
  localparam int DEVFN_LSB = 24;
  localparam int OPC_LSB   = 16;
  localparam int PORT_LSB  = 8;
  localparam int BE_LSB    = 4;
  localparam int BAR_LSB   = 1;
  localparam int FIELD_W   = 8;
  localparam int BE_W      = 4;
  localparam int BAR_W     = 3;

  // control register flag positions
  localparam int TMO_FLAG_BIT = 16;
  localparam int OVR_FLAG_BIT = 17;

  // opcodes classified as reads
  localparam logic [7:0] OPC_MMIO_RD = 8'h00;
  localparam logic [7:0] OPC_PRIV_RD = 8'h06;

  typedef struct packed {
    logic wrAddr;
    logic wrData;
    logic launch;
    logic wrCtl;
    logic loadRsp;
    logic loadOnes;
    logic busy;
    logic reqActive;
    logic tmoFlag;
    logic ovrFlag;
  } sbbStrobes_t;
endpackage

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
  import sbb_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic [1:0]       hostSel,
  input  logic [1:0]       clrReq,
  input  logic             cmdIsRead,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic             fabReqReady,
  input  logic             fabRspValid,
  output sbbStrobes_t      strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_t;

  state_t           state;
  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] limLatched;
  logic             tmoFlag;
  logic             ovrFlag;
  logic             idle;
  logic             launch;
  logic             overrun;
  logic             wrCtl;
  logic             rspHit;
  logic             tmoHit;

  always_comb begin
    idle    = (state == ST_IDLE);
    launch  = hostWe && (hostSel == SEL_BELL) && idle;
    overrun = hostWe && (hostSel == SEL_BELL) && !idle;
    wrCtl   = hostWe && (hostSel == SEL_CTL);
    rspHit  = (state == ST_WAIT) && fabRspValid;
    tmoHit  = !idle && !rspHit && (cnt == limLatched);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      limLatched <= '0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          state      <= ST_REQ;
          cnt        <= '0;
          limLatched <= tmoLimit;
        end
        ST_REQ: begin
          if (tmoHit) state <= ST_IDLE;
          else begin
            cnt <= cnt + TMO_W'(1);
            if (fabReqReady) state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rspHit || tmoHit) state <= ST_IDLE;
          else cnt <= cnt + TMO_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      if (tmoHit) tmoFlag <= 1'b1;
      else if (wrCtl && clrReq[0]) tmoFlag <= 1'b0;
      if (overrun) ovrFlag <= 1'b1;
      else if (wrCtl && clrReq[1]) ovrFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.wrAddr    = hostWe && (hostSel == SEL_ADDR) && idle;
    strb.wrData    = hostWe && (hostSel == SEL_DATA) && idle;
    strb.launch    = launch;
    strb.wrCtl     = wrCtl;
    strb.loadRsp   = rspHit && cmdIsRead;
    strb.loadOnes  = tmoHit && cmdIsRead;
    strb.busy      = !idle;
    strb.reqActive = (state == ST_REQ);
    strb.tmoFlag   = tmoFlag;
    strb.ovrFlag   = ovrFlag;
  end

  // R2
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !idle);

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idle |-> (cnt <= limLatched));

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> ($past(fabRspValid) || $past(cnt == limLatched)));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !(wrCtl && clrReq[1])) |=> ovrFlag);

endmodule

// File: rtl/sbb_datapath.sv
module sbb_datapath
  import sbb_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int TMO_W       = 16,
  parameter int DEFAULT_TMO = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           hostSel,
  input  logic [31:0]          hostWdata,
  output logic [31:0]          hostRdata,
  input  sbbStrobes_t          strb,
  output logic                 cmdIsRead,
  output logic [TMO_W-1:0]     tmoLimit,
  output logic [NUM_PORTS-1:0] fabReqValid,
  output logic [FIELD_W-1:0]   fabDevFn,
  output logic [FIELD_W-1:0]   fabOpcode,
  output logic [BE_W-1:0]      fabByteEn,
  output logic [BAR_W-1:0]     fabBar,
  output logic [31:0]          fabAddr,
  output logic [31:0]          fabWdata,
  input  logic [31:0]          fabRspData
);

  logic [31:0]        addrReg;
  logic [31:0]        dataReg;
  logic [31:1]        cmdReg;
  logic [TMO_W-1:0]   limitReg;
  logic [FIELD_W-1:0] portField;
  logic [31:0]        ctlView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      dataReg  <= '0;
      cmdReg   <= '0;
      limitReg <= TMO_W'(DEFAULT_TMO);
    end else begin
      if (strb.wrAddr) addrReg <= hostWdata;
      if (strb.loadRsp)       dataReg <= fabRspData;
      else if (strb.loadOnes) dataReg <= '1;
      else if (strb.wrData)   dataReg <= hostWdata;
      if (strb.launch) cmdReg <= hostWdata[31:1];
      if (strb.wrCtl)  limitReg <= hostWdata[TMO_W-1:0];
    end
  end

  always_comb begin
    fabDevFn  = cmdReg[DEVFN_LSB +: FIELD_W];
    fabOpcode = cmdReg[OPC_LSB +: FIELD_W];
    portField = cmdReg[PORT_LSB +: FIELD_W];
    fabByteEn = cmdReg[BE_LSB +: BE_W];
    fabBar    = cmdReg[BAR_LSB +: BAR_W];
    cmdIsRead = (fabOpcode == OPC_MMIO_RD) || (fabOpcode == OPC_PRIV_RD);
    fabAddr   = addrReg;
    fabWdata  = dataReg;
    tmoLimit  = limitReg;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_route
    assign fabReqValid[p] = strb.reqActive && (portField == FIELD_W'(p));
  end

  always_comb begin
    ctlView               = 32'(limitReg);
    ctlView[TMO_FLAG_BIT] = strb.tmoFlag;
    ctlView[OVR_FLAG_BIT] = strb.ovrFlag;
    case (hostSel)
      SEL_ADDR: hostRdata = addrReg;
      SEL_DATA: hostRdata = dataReg;
      SEL_BELL: hostRdata = {cmdReg, strb.busy};
      default:  hostRdata = ctlView;
    endcase
  end

  // R3
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fabReqValid));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(addrReg));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.loadRsp && !strb.loadOnes) |=> $stable(dataReg));

endmodule

// File: rtl/sb_mailbox_bridge.sv
module sb_mailbox_bridge
  import sbb_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int TMO_W       = 16,
  parameter int DEFAULT_TMO = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWe,
  input  logic [1:0]           hostSel,
  input  logic [31:0]          hostWdata,
  output logic [31:0]          hostRdata,
  output logic [NUM_PORTS-1:0] fabReqValid,
  input  logic                 fabReqReady,
  output logic [7:0]           fabDevFn,
  output logic [7:0]           fabOpcode,
  output logic [3:0]           fabByteEn,
  output logic [2:0]           fabBar,
  output logic                 fabIsRead,
  output logic [31:0]          fabAddr,
  output logic [31:0]          fabWdata,
  input  logic                 fabRspValid,
  input  logic [31:0]          fabRspData
);

  sbbStrobes_t      strb;
  logic             cmdIsRead;
  logic [TMO_W-1:0] tmoLimit;

  sbb_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostWe      (hostWe),
    .hostSel     (hostSel),
    .clrReq      (hostWdata[OVR_FLAG_BIT:TMO_FLAG_BIT]),
    .cmdIsRead   (cmdIsRead),
    .tmoLimit    (tmoLimit),
    .fabReqReady (fabReqReady),
    .fabRspValid (fabRspValid),
    .strb        (strb)
  );

  sbb_datapath #(
    .NUM_PORTS   (NUM_PORTS),
    .TMO_W       (TMO_W),
    .DEFAULT_TMO (DEFAULT_TMO)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hostSel     (hostSel),
    .hostWdata   (hostWdata),
    .hostRdata   (hostRdata),
    .strb        (strb),
    .cmdIsRead   (cmdIsRead),
    .tmoLimit    (tmoLimit),
    .fabReqValid (fabReqValid),
    .fabDevFn    (fabDevFn),
    .fabOpcode   (fabOpcode),
    .fabByteEn   (fabByteEn),
    .fabBar      (fabBar),
    .fabAddr     (fabAddr),
    .fabWdata    (fabWdata),
    .fabRspData  (fabRspData)
  );

  assign fabIsRead = cmdIsRead;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|fabReqValid) && !fabReqReady) |=>
      ($stable(fabOpcode) && $stable(fabAddr) && $stable(fabWdata) && $stable(fabDevFn)));

endmodule

// File: tb/tb_sb_mailbox_bridge.sv
`timescale 1ns/1ps
module tb_sb_mailbox_bridge;
  localparam int NP   = 4;
  localparam int TW   = 8;
  localparam int DTMO = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWe = 1'b0;
  logic [1:0]    hostSel = 2'd0;
  logic [31:0]   hostWdata = '0;
  logic [31:0]   hostRdata;
  logic [NP-1:0] fabReqValid;
  logic          fabReqReady = 1'b0;
  logic [7:0]    fabDevFn, fabOpcode;
  logic [3:0]    fabByteEn;
  logic [2:0]    fabBar;
  logic          fabIsRead;
  logic [31:0]   fabAddr, fabWdata;
  logic          fabRspValid = 1'b0;
  logic [31:0]   fabRspData = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  sb_mailbox_bridge #(.NUM_PORTS(NP), .TMO_W(TW), .DEFAULT_TMO(DTMO)) dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .fabReqValid(fabReqValid),
    .fabReqReady(fabReqReady), .fabDevFn(fabDevFn), .fabOpcode(fabOpcode),
    .fabByteEn(fabByteEn), .fabBar(fabBar), .fabIsRead(fabIsRead),
    .fabAddr(fabAddr), .fabWdata(fabWdata), .fabRspValid(fabRspValid),
    .fabRspData(fabRspData)
  );

  typedef struct packed {
    logic [7:0]  devfn;
    logic [7:0]  op;
    logic [7:0]  port;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rsp;
    logic [3:0]  rdyDly;
    logic [3:0]  rspDly;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h06, 8'h00, 32'h0000_0010, 32'h0000_0000, 32'hDEAD_BEEF, 4'd0, 4'd1},
    '{8'h00, 8'h07, 8'h01, 32'h0000_0024, 32'h1234_5678, 32'h0000_0000, 4'd2, 4'd0},
    '{8'h10, 8'h00, 8'h02, 32'h0000_1000, 32'h0000_0000, 32'hA5A5_0001, 4'd1, 4'd3},
    '{8'h10, 8'h01, 8'h03, 32'h0000_2004, 32'hCAFE_F00D, 32'hFFFF_0000, 4'd3, 4'd2},
    '{8'h00, 8'h05, 8'h01, 32'h0000_0008, 32'h55AA_55AA, 32'h1111_1111, 4'd0, 4'd0},
    '{8'h00, 8'h06, 8'h03, 32'h0000_003C, 32'h0000_0000, 32'h7E57_0042, 4'd0, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0; hostWdata = '0;
  endtask

  task automatic hread(input logic [1:0] sel, output logic [31:0] v);
    hostSel = sel;
    #0.5;
    v = hostRdata;
  endtask

  function automatic logic [31:0] mkCmd(input logic [7:0] dfn, input logic [7:0] op, input logic [7:0] port);
    return {dfn, op, port, 4'hF, 3'b000, 1'b0};
  endfunction

  function automatic logic [NP-1:0] route(input logic [7:0] port);
    return (port < NP) ? (NP'(1) << port) : '0;
  endfunction

  task automatic runVec(input vec_t v);
    logic [31:0] r;
    logic isRd;
    logic [31:0] cmd;
    isRd = (v.op == 8'h00) || (v.op == 8'h06);
    cmd  = mkCmd(v.devfn, v.op, v.port);
    hwrite(2'd0, v.addr);
    hwrite(2'd1, isRd ? 32'h0 : v.wdata);
    hwrite(2'd2, cmd);
    hread(2'd2, r);
    chk("R2 doorbell readback with busy", r, cmd | 32'h1);
    chk("R3 one-hot route", 32'(fabReqValid), 32'(route(v.port)));
    chk("R4 devfn/opcode/be/bar", {fabDevFn, fabOpcode, 12'(fabByteEn), 4'(fabBar)},
        {v.devfn, v.op, 12'hF, 4'h0});
    chk("R4 address/data", fabAddr ^ fabWdata, v.addr ^ (isRd ? 32'h0 : v.wdata));
    chk("R5 read flag", 32'(fabIsRead), 32'(isRd));
    repeat (v.rdyDly) @(negedge clk);
    chk("R3 valid held until ready", 32'(fabReqValid), 32'(route(v.port)));
    fabReqReady = 1'b1;
    @(negedge clk);
    fabReqReady = 1'b0;
    chk("R3 valid dropped after ready", 32'(fabReqValid), 32'h0);
    repeat (v.rspDly) @(negedge clk);
    fabRspValid = 1'b1; fabRspData = v.rsp;
    @(negedge clk);
    fabRspValid = 1'b0; fabRspData = '0;
    hread(2'd2, r);
    chk(isRd ? "R6 busy clear after read" : "R7 busy clear after write", 32'(r[0]), 32'h0);
    hread(2'd1, r);
    if (isRd) chk("R6 read data captured", r, v.rsp);
    else      chk("R7 data kept on write", r, v.wdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] cmdA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    hread(2'd0, r); chk("R1 address reset", r, 32'h0);
    hread(2'd1, r); chk("R1 data reset", r, 32'h0);
    hread(2'd2, r); chk("R1 doorbell reset", r, 32'h0);
    hread(2'd3, r); chk("R1 control reset", r, 32'(DTMO));
    chk("R1 no request", 32'(fabReqValid), 32'h0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R10 timeout on a read whose port has no route; limit rewritten (R11)
    hwrite(2'd3, 32'h0000_0005);
    hread(2'd3, r); chk("R11 limit written", r, 32'h5);
    hwrite(2'd0, 32'h0000_0100);
    hwrite(2'd1, 32'h0);
    hwrite(2'd2, mkCmd(8'h00, 8'h06, 8'h07));
    chk("R3 out-of-range port raises nothing", 32'(fabReqValid), 32'h0);
    repeat (5) @(negedge clk);
    hread(2'd2, r); chk("R10 still busy at limit", 32'(r[0]), 32'h1);
    @(negedge clk);
    hread(2'd2, r); chk("R10 busy cleared on expiry", 32'(r[0]), 32'h0);
    hread(2'd1, r); chk("R10 read timeout data all ones", r, 32'hFFFF_FFFF);
    hread(2'd3, r); chk("R10 timeout flag set", r, 32'h0001_0005);

    // R11 clear timeout flag only
    hwrite(2'd3, 32'h0001_0005);
    hread(2'd3, r); chk("R11 timeout flag cleared", r, 32'h5);

    // R10 write accepted but never answered
    hwrite(2'd0, 32'h0000_0200);
    hwrite(2'd1, 32'h0BAD_F00D);
    hwrite(2'd2, mkCmd(8'h00, 8'h07, 8'h02));
    fabReqReady = 1'b1;
    @(negedge clk);
    fabReqReady = 1'b0;
    repeat (4) @(negedge clk);
    hread(2'd2, r); chk("R10 write still busy at limit", 32'(r[0]), 32'h1);
    @(negedge clk);
    hread(2'd2, r); chk("R10 write busy cleared", 32'(r[0]), 32'h0);
    hread(2'd1, r); chk("R10 write timeout keeps data", r, 32'h0BAD_F00D);
    chk("R10 no valid after timeout", 32'(fabReqValid), 32'h0);

    // R11 clear both flags, restore limit
    hwrite(2'd3, 32'h0003_000C);
    hread(2'd3, r); chk("R11 flags cleared and limit", r, 32'h0000_000C);

    // R8 / R9 writes while busy are ignored
    cmdA = mkCmd(8'h20, 8'h07, 8'h00);
    hwrite(2'd0, 32'h0000_0300);
    hwrite(2'd1, 32'h1357_9BDF);
    hwrite(2'd2, cmdA);
    hwrite(2'd2, mkCmd(8'h30, 8'h06, 8'h02));
    hwrite(2'd0, 32'hFFFF_0000);
    hwrite(2'd1, 32'h0000_FFFF);
    hread(2'd2, r); chk("R8 doorbell unchanged while busy", r, cmdA | 32'h1);
    hread(2'd0, r); chk("R9 address unchanged while busy", r, 32'h0000_0300);
    hread(2'd1, r); chk("R9 data unchanged while busy", r, 32'h1357_9BDF);
    hread(2'd3, r); chk("R8 overrun flag set", r, 32'h0002_000C);
    chk("R8 route unchanged", 32'(fabReqValid), 32'h1);
    fabReqReady = 1'b1;
    @(negedge clk);
    fabReqReady = 1'b0;
    fabRspValid = 1'b1; fabRspData = 32'h2468_ACE0;
    @(negedge clk);
    fabRspValid = 1'b0; fabRspData = '0;
    hread(2'd2, r); chk("R7 busy clear", 32'(r[0]), 32'h0);
    hread(2'd3, r); chk("R8 overrun sticky", r, 32'h0002_000C);
    hwrite(2'd3, 32'h0001_000C);
    hread(2'd3, r); chk("R11 zero bit leaves overrun", r, 32'h0002_000C);
    hwrite(2'd3, 32'h0002_000C);
    hread(2'd3, r); chk("R11 overrun cleared", r, 32'h0000_000C);

    // R12 stray response while idle
    @(negedge clk);
    fabRspValid = 1'b1; fabRspData = 32'h9999_9999;
    @(negedge clk);
    fabRspValid = 1'b0; fabRspData = '0;
    hread(2'd1, r); chk("R12 idle response ignored", r, 32'h1357_9BDF);
    hread(2'd2, r); chk("R12 still idle", 32'(r[0]), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule